// File: doc/BRIEF.md
# Masked Vector Lane Writeback with Broadcast

This block wraps a per-element double-precision operation so that it runs across a whole vector register of 2, 4 or 8 lanes of 64 bits (register widths of 128, 256 or 512 bits). Each lane either takes the operation result or, when the write mask leaves it out, keeps the old destination lane (merging) or is cleared (zeroing). When the operand comes from memory and broadcast is requested, the low 64-bit element feeds every lane. Bits above the selected register width always come out as zero.

A reserved 4-bit register-specifier field must hold all ones. Any other value, or the unused length code, raises a fault and leaves the destination untouched. Per-lane exception flags (a NaN operand in this build) are folded into one flag, counting only lanes that are really computed. The operation itself is a small combinational lane module that the parameter `OP_KIND` selects; the default flips the sign of ordinary values and quiets NaNs. One request is accepted per cycle and its result is registered.

Top module: `simd_lane_wb`

## Requirements
- R1: `vlen_sel` encodes the active lane count: 0 gives 2 lanes, 1 gives 4 lanes, 2 gives 8 lanes; lane j spans bits [64j+63:64j].
- R2: An active lane j takes the lane operation result when `mask_en` is 0 or when `wmask[j]` is 1.
- R3: When `bcast_en` and `src_is_mem` are both 1, every active lane operates on `src_vec[63:0]`; when either is 0, lane j operates on its own slice of `src_vec`.
- R4: With `zero_en` = 0, an active lane that is not selected by the mask outputs its `old_dst` lane unchanged.
- R5: With `zero_en` = 1, an active lane that is not selected by the mask outputs zero.
- R6: All output bits from the active width up to bit 511 are zero on a non-faulting request, whatever the mask, zeroing and old destination.
- R7: When `reg_spec` differs from 4'b1111, or `vlen_sel` is 3, `fault_out` is 1, `dst_out` equals the whole `old_dst` and `exc_out` is 0; otherwise `fault_out` is 0.
- R8: `exc_out` is 1 exactly when some selected active lane has a NaN operand (exponent bits [62:52] all ones and fraction [51:0] nonzero); NaNs in unselected or inactive lanes are ignored.
- R9: With the default operation, a non-NaN operand returns with bit 63 inverted and a NaN operand returns with bit 51 set and all other bits unchanged.
- R10: The outputs of a request with `in_valid` = 1 appear on the next clock edge together with a one-cycle `out_valid`; in cycles without a request `out_valid` is 0 and `dst_out`, `fault_out`, `exc_out` hold.
- R11: Synchronous reset clears `out_valid`, `dst_out`, `fault_out` and `exc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src_vec | input | 512 | Source operand vector |
| old_dst | input | 512 | Previous destination contents |
| wmask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Mask in use |
| zero_en | input | 1 | Zeroing instead of merging for unselected lanes |
| bcast_en | input | 1 | Broadcast of element 0 requested |
| src_is_mem | input | 1 | Operand comes from memory |
| vlen_sel | input | 2 | Register width code |
| reg_spec | input | 4 | Reserved field, must be 4'b1111 |
| out_valid | output | 1 | Result strobe |
| dst_out | output | 512 | Full-width destination |
| fault_out | output | 1 | Undefined-request fault |
| exc_out | output | 1 | OR of exception flags of computed lanes |

## Verification
Every result is due exactly one clock edge after the request that carries it: the bench drives a request on a falling edge, lets one rising edge pass and reads the outputs at the next falling edge, so no sample races the register. An idle falling edge follows each request or burst and is used to confirm that `out_valid` has dropped and the outputs held. Directed cases cover each length, broadcast with and without a memory operand, both masking styles, faults and NaN placement, then seeded random requests are compared against a bench model of the whole vector.

// File: rtl/simd_wb_pkg.sv
package simd_wb_pkg;

    localparam int LANE_BITS   = 64;
    localparam int LANES_MAX   = 8;
    localparam logic [3:0] SPEC_OK = 4'b1111;

    typedef enum logic [1:0] {
        VL_W128 = 2'd0,
        VL_W256 = 2'd1,
        VL_W512 = 2'd2,
        VL_BAD  = 2'd3
    } vlen_e;

    typedef struct packed {
        logic       mask_en;
        logic       zero_en;
        logic       bcast_en;
        logic       from_mem;
        vlen_e      vlen;
        logic [3:0] spec;
    } wb_ctrl_t;

    // Number of lanes that a width code enables; zero for the unused code.
    function automatic logic [3:0] lanes_of(input vlen_e v);
        case (v)
            VL_W128: return 4'd2;
            VL_W256: return 4'd4;
            VL_W512: return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    // Double-precision NaN test: exponent all ones, fraction nonzero.
    function automatic logic fp64_is_nan(input logic [63:0] x);
        return (&x[62:52]) && (|x[51:0]);
    endfunction

    function automatic logic request_faults(input wb_ctrl_t c);
        return (c.spec != SPEC_OK) || (c.vlen == VL_BAD);
    endfunction

endpackage

// File: rtl/lane_fetch.sv
module lane_fetch #(
    parameter int LANE_W = 64
) (
    input  logic [LANE_W-1:0] elem0,
    input  logic [LANE_W-1:0] own,
    input  logic              take_elem0,
    output logic [LANE_W-1:0] opnd
);
    always_comb begin
        opnd = take_elem0 ? elem0 : own;
    end
endmodule

// File: rtl/lane_op.sv
module lane_op #(
    parameter int LANE_W  = 64,
    parameter int OP_KIND = 1
) (
    input  logic [LANE_W-1:0] a,
    output logic [LANE_W-1:0] y,
    output logic              exc
);
    import simd_wb_pkg::*;

    logic nan_in;
    assign nan_in = fp64_is_nan(a[63:0]);
    assign exc    = nan_in;

    generate
        if (OP_KIND == 0) begin : g_pass
            always_comb begin
                y = a;
                if (nan_in) y[51] = 1'b1;
            end
        end else begin : g_negate
            always_comb begin
                y = a;
                if (nan_in) y[51] = 1'b1;
                else        y[LANE_W-1] = ~a[LANE_W-1];
            end
        end
    endgenerate
endmodule

// File: rtl/lane_write.sv
module lane_write #(
    parameter int LANE_W = 64
) (
    input  logic [LANE_W-1:0] res,
    input  logic [LANE_W-1:0] prev,
    input  logic              active,
    input  logic              chosen,
    input  logic              zeroing,
    output logic [LANE_W-1:0] wr
);
    always_comb begin
        if (!active)      wr = '0;
        else if (chosen)  wr = res;
        else if (zeroing) wr = '0;
        else              wr = prev;
    end
endmodule

// File: rtl/simd_lane_wb.sv
module simd_lane_wb #(
    parameter int LANE_W    = simd_wb_pkg::LANE_BITS,
    parameter int MAX_LANES = simd_wb_pkg::LANES_MAX,
    parameter int OP_KIND   = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [LANE_W*MAX_LANES-1:0]   src_vec,
    input  logic [LANE_W*MAX_LANES-1:0]   old_dst,
    input  logic [MAX_LANES-1:0]          wmask,
    input  logic                          mask_en,
    input  logic                          zero_en,
    input  logic                          bcast_en,
    input  logic                          src_is_mem,
    input  logic [1:0]                    vlen_sel,
    input  logic [3:0]                    reg_spec,
    output logic                          out_valid,
    output logic [LANE_W*MAX_LANES-1:0]   dst_out,
    output logic                          fault_out,
    output logic                          exc_out
);
    import simd_wb_pkg::*;

    localparam int VEC_W = LANE_W * MAX_LANES;

    wb_ctrl_t             ctl;
    logic                 fault_c;
    logic [3:0]           nlanes;
    logic                 take0;
    logic [VEC_W-1:0]     dst_c;
    logic [MAX_LANES-1:0] exc_vec;

    always_comb begin
        ctl.mask_en  = mask_en;
        ctl.zero_en  = zero_en;
        ctl.bcast_en = bcast_en;
        ctl.from_mem = src_is_mem;
        ctl.vlen     = vlen_e'(vlen_sel);
        ctl.spec     = reg_spec;
    end

    assign fault_c = request_faults(ctl);
    assign nlanes  = lanes_of(ctl.vlen);
    assign take0   = ctl.bcast_en && ctl.from_mem;

    generate
        for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
            localparam int unsigned IDX = j;
            logic [LANE_W-1:0] opnd;
            logic [LANE_W-1:0] res;
            logic [LANE_W-1:0] wr;
            logic              lane_exc;
            logic              active;
            logic              chosen;

            assign active = (nlanes > 4'(IDX));
            assign chosen = active && (!ctl.mask_en || wmask[j]);

            lane_fetch #(.LANE_W(LANE_W)) fetch_i (
                .elem0      (src_vec[LANE_W-1:0]),
                .own        (src_vec[j*LANE_W +: LANE_W]),
                .take_elem0 (take0),
                .opnd       (opnd)
            );

            lane_op #(.LANE_W(LANE_W), .OP_KIND(OP_KIND)) op_i (
                .a   (opnd),
                .y   (res),
                .exc (lane_exc)
            );

            lane_write #(.LANE_W(LANE_W)) write_i (
                .res     (res),
                .prev    (old_dst[j*LANE_W +: LANE_W]),
                .active  (active),
                .chosen  (chosen),
                .zeroing (ctl.zero_en),
                .wr      (wr)
            );

            assign dst_c[j*LANE_W +: LANE_W] = wr;
            assign exc_vec[j] = chosen && lane_exc;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst_out   <= '0;
            fault_out <= 1'b0;
            exc_out   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_out   <= fault_c ? old_dst : dst_c;
                fault_out <= fault_c;
                exc_out   <= !fault_c && (|exc_vec);
            end
        end
    end
endmodule

// File: rtl/simd_lane_wb_chk.sv
module simd_lane_wb_chk #(
    parameter int LANE_W    = 64,
    parameter int MAX_LANES = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic [LANE_W*MAX_LANES-1:0] old_dst,
    input logic [1:0]                  vlen_sel,
    input logic [3:0]                  reg_spec,
    input logic                        out_valid,
    input logic [LANE_W*MAX_LANES-1:0] dst_out,
    input logic                        fault_out,
    input logic                        exc_out
);
    localparam int VEC_W = LANE_W * MAX_LANES;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(dst_out) && $stable(fault_out) && $stable(exc_out)));

    // R7
    fault_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && fault_out) |-> (dst_out == $past(old_dst)));

    // R7
    fault_when_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (reg_spec != 4'b1111)) |=> fault_out);

    // R7
    fault_no_exc_chk: assert property (@(posedge clk) disable iff (rst)
        fault_out |-> !exc_out);

    // R6
    upper_zero_128_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen_sel == 2'd0 && reg_spec == 4'b1111)
            |=> (dst_out[VEC_W-1:2*LANE_W] == '0));

    // R6
    upper_zero_256_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen_sel == 2'd1 && reg_spec == 4'b1111)
            |=> (dst_out[VEC_W-1:4*LANE_W] == '0));
endmodule

bind simd_lane_wb simd_lane_wb_chk #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .old_dst   (old_dst),
    .vlen_sel  (vlen_sel),
    .reg_spec  (reg_spec),
    .out_valid (out_valid),
    .dst_out   (dst_out),
    .fault_out (fault_out),
    .exc_out   (exc_out)
);

// File: tb/simd_lane_wb_tb_top.sv
`timescale 1ns/1ps
module simd_lane_wb_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [511:0] src_vec;
    logic [511:0] old_dst;
    logic [7:0]   wmask;
    logic         mask_en, zero_en, bcast_en, src_is_mem;
    logic [1:0]   vlen_sel;
    logic [3:0]   reg_spec;
    logic         out_valid;
    logic [511:0] dst_out;
    logic         fault_out, exc_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    simd_lane_wb dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
        .old_dst(old_dst), .wmask(wmask), .mask_en(mask_en), .zero_en(zero_en),
        .bcast_en(bcast_en), .src_is_mem(src_is_mem), .vlen_sel(vlen_sel),
        .reg_spec(reg_spec), .out_valid(out_valid), .dst_out(dst_out),
        .fault_out(fault_out), .exc_out(exc_out)
    );

    function automatic logic m_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 52'd0);
    endfunction

    function automatic logic [63:0] m_op(input logic [63:0] x);
        if (m_nan(x)) return x | (64'd1 << 51);
        return {~x[63], x[62:0]};
    endfunction

    function automatic logic m_fault();
        return (reg_spec != 4'hF) || (vlen_sel == 2'd3);
    endfunction

    function automatic logic [511:0] m_dst();
        logic [511:0] d = '0;
        int n;
        if (m_fault()) return old_dst;
        n = 2 << vlen_sel;
        for (int j = 0; j < 8; j++) begin
            logic [63:0] a;
            a = (bcast_en && src_is_mem) ? src_vec[63:0] : src_vec[j*64 +: 64];
            if (j < n) begin
                if (!mask_en || wmask[j]) d[j*64 +: 64] = m_op(a);
                else if (!zero_en)        d[j*64 +: 64] = old_dst[j*64 +: 64];
            end
        end
        return d;
    endfunction

    function automatic logic m_exc();
        logic e = 1'b0;
        int n;
        if (m_fault()) return 1'b0;
        n = 2 << vlen_sel;
        for (int j = 0; j < 8; j++) begin
            logic [63:0] a;
            a = (bcast_en && src_is_mem) ? src_vec[63:0] : src_vec[j*64 +: 64];
            if (j < n && (!mask_en || wmask[j]) && m_nan(a)) e = 1'b1;
        end
        return e;
    endfunction

    function automatic logic [63:0] r64();
        logic [63:0] v;
        v = {$urandom(), $urandom()};
        if ($urandom_range(0, 5) == 0) v[62:52] = 11'h7FF;
        return v;
    endfunction

    function automatic logic [511:0] r512();
        logic [511:0] v;
        for (int j = 0; j < 8; j++) v[j*64 +: 64] = r64();
        return v;
    endfunction

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input string tag);
        logic [511:0] ed;
        logic ef, ee;
        ed = m_dst(); ef = m_fault(); ee = m_exc();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R10 out_valid"}, {511'd0, out_valid}, 512'd1);
        chk({tag, " dst"},   dst_out, ed);
        chk({tag, " fault"}, {511'd0, fault_out}, {511'd0, ef});
        chk({tag, " exc"},   {511'd0, exc_out}, {511'd0, ee});
    endtask

    task automatic idle_check();
        logic [511:0] d;
        logic f, e;
        d = dst_out; f = fault_out; e = exc_out;
        src_vec = r512(); old_dst = r512();
        @(negedge clk);
        chk("R10 idle valid", {511'd0, out_valid}, 512'd0);
        chk("R10 idle hold", {dst_out, fault_out, exc_out} >> 2, {d, f, e} >> 2);
        chk("R10 idle hold flags", {510'd0, fault_out, exc_out}, {510'd0, f, e});
    endtask

    task automatic setup(input logic [1:0] vl, input logic me, input logic [7:0] m,
                         input logic z, input logic b, input logic mem);
        vlen_sel = vl; mask_en = me; wmask = m; zero_en = z;
        bcast_en = b; src_is_mem = mem; reg_spec = 4'hF;
        src_vec = r512(); old_dst = r512();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7391));
        rst = 1'b1; in_valid = 1'b0;
        setup(2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R11 reset", {dst_out, out_valid, fault_out, exc_out} >> 3, 512'd0);
        chk("R11 reset flags", {509'd0, out_valid, fault_out, exc_out}, 512'd0);
        rst = 1'b0;

        // R1 and R6: each width, no mask
        for (int v = 0; v < 3; v++) begin
            setup(2'(v), 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
            run_req("R1 width");
            if (v < 2) chk("R6 upper zero", dst_out >> (128 << v), 512'd0);
        end
        idle_check();

        // R2 and R4: merging with a mask
        setup(2'd2, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
        run_req("R2 R4 merge");
        chk("R4 kept lane1", {448'd0, dst_out[127:64]}, {448'd0, old_dst[127:64]});
        // R5: zeroing
        setup(2'd1, 1'b1, 8'h06, 1'b1, 1'b0, 1'b0);
        run_req("R5 zero");
        chk("R5 zeroed lane0", {448'd0, dst_out[63:0]}, 512'd0);
        // R6: mask bits above width do not write
        setup(2'd0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
        run_req("R6 mask high");
        idle_check();

        // R3: broadcast with and without memory source
        setup(2'd2, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
        src_vec[63:0] = 64'h4000_0000_0000_0000;
        run_req("R3 bcast mem");
        chk("R3 lane7 from elem0", {448'd0, dst_out[511:448]}, {448'd0, 64'hC000_0000_0000_0000});
        setup(2'd2, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        run_req("R3 bcast reg");
        setup(2'd1, 1'b1, 8'h0C, 1'b1, 1'b1, 1'b1);
        run_req("R3 bcast masked");

        // R7: faults
        setup(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        reg_spec = 4'hE;
        run_req("R7 spec");
        setup(2'd3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        run_req("R7 vlen3");
        idle_check();

        // R8: NaN placement
        setup(2'd1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
        src_vec = '0; src_vec[127:64] = 64'h7FF0_0000_0000_0001;
        run_req("R8 nan unselected");
        chk("R8 unselected exc", {511'd0, exc_out}, 512'd0);
        wmask = 8'h02;
        run_req("R8 nan selected");
        chk("R8 selected exc", {511'd0, exc_out}, 512'd1);
        setup(2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        src_vec = '0; src_vec[255:192] = 64'h7FF8_0000_0000_0000;
        run_req("R8 nan inactive");

        // R9: operation values
        setup(2'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        src_vec = '0;
        src_vec[63:0]   = 64'h3FF0_0000_0000_0000;
        src_vec[127:64] = 64'h7FF0_0000_0000_0001;
        run_req("R9 op");
        chk("R9 lane0", {448'd0, dst_out[63:0]}, {448'd0, 64'hBFF0_0000_0000_0000});
        chk("R9 lane1", {448'd0, dst_out[127:64]}, {448'd0, 64'h7FF8_0000_0000_0001});
        idle_check();

        // Random mix over all requirements (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 300; i++) begin
            setup(2'($urandom_range(0, 2)), 1'($urandom()), 8'($urandom()),
                  1'($urandom()), 1'($urandom()), 1'($urandom()));
            if ($urandom_range(0, 15) == 0) reg_spec = 4'($urandom());
            if ($urandom_range(0, 15) == 0) vlen_sel = 2'd3;
            run_req("R2 random");
            if ((i % 25) == 0) idle_check();
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule